// File: doc/BRIEF.md
# Shadow-backed SRAM store/recall controller

A synchronous word-wide static RAM in which every word has a nonvolatile shadow copy. In RAM mode, with the nonvolatile select input high, the block is an ordinary single-port memory. It has active-low chip-enable, write-enable and output-enable inputs, a registered read path and a separate output-valid flag that stands in for the tri-state data bus.

Two whole-array transfers are provided. STORE copies the working RAM into the shadow array. RECALL first zeroes the working RAM and then loads it from the shadow array. Either transfer can be started in two ways. One is a pin condition with the nonvolatile select low. The other is a software unlock: six chip-enabled reads at fixed addresses, where the sixth address chooses the transfer. Leaving reset always performs a RECALL. While a transfer runs, the block raises `busy` and ignores all accesses. It raises `done` for one cycle when the transfer finishes.

Top module: `sram_shadow_ctrl`

## Requirements
- R1: In RAM mode (`nv_n`=1) a cycle with `ce_n`=0 and `we_n`=0 writes `din` to `addr`. A cycle with `ce_n`=0, `we_n`=1 and `oe_n`=0 presents that word on `dout` with `dout_en`=1 in the following cycle.
- R2: When the previous cycle was not a RAM read with `oe_n`=0, `dout_en` is 0 and `dout` is 0. This includes a read with `oe_n`=1.
- R3: With `nv_n`=0, no RAM read or write takes place. `dout_en` stays 0, and `din` from that cycle is never written.
- R4: `nv_n`=0 with `ce_n`=0 and `we_n`=0 starts a STORE. The STORE copies every RAM word into the shadow and keeps `busy` high for STORE_CYC cycles. Only the first cycle of a held condition triggers a transfer.
- R5: `nv_n`=0 with `ce_n`=0, `we_n`=1 and `oe_n`=0 starts a RECALL that keeps `busy` high for RECALL_CYC cycles. Only the first cycle of a held condition triggers a transfer.
- R6: Chip-enabled RAM reads at 0x4E3, 0x0B8, 0x744, 0x3C3, 0x0F8 and then 0x13F start a STORE. Idle cycles with `ce_n`=1 may come between the reads.
- R7: The same five reads followed by a read at 0x0C7 start a RECALL.
- R8: Any other chip-enabled access during the unlock returns the matcher to its first step. This covers a write, or a read at an unexpected address. No transfer results.
- R9: While `busy` is high, writes are dropped and `dout_en` stays 0.
- R10: RECALL zeroes the RAM for RECALL_CYC/2 cycles and then loads the shadow contents. Afterwards every word equals the last stored value, whatever the RAM held before. The shadow is left unchanged, so the RECALL can be repeated.
- R11: Leaving reset starts a RECALL. `busy` is high during reset and stays high for RECALL_CYC cycles after release.
- R12: `done` is high for exactly one cycle, in the first cycle after a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile select, low = transfer mode |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Read data valid (bus driven) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
Several properties are checked on every cycle. The output flag is held low during a transfer and in transfer mode. `done` is a single-cycle pulse that only follows a busy period. `busy` is present at reset release. Other behaviours can only be shown by the bench's scenarios. These include the word-level effect of STORE and RECALL, transfer length, and the one-shot behaviour of a held pin trigger. They also include matching and aborting of the unlock sequence, and survival of stored data across a second reset. In each scenario, values written before and after the transfer are later read back.

// File: rtl/sram_shadow_ctrl.sv
module sram_shadow_ctrl #(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          nv_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          busy,
  output logic          done
);
  localparam int WORDS = 2 ** AW;
  localparam int HALF  = RECALL_CYC / 2;
  localparam int MAXC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW    = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] ST_LAST  = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] LD_LAST  = CW'(RECALL_CYC - HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_RCLR, S_RLOAD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic          hw_st_q, hw_rc_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] ram    [WORDS];
  logic [DW-1:0] shadow [WORDS];

  function automatic logic [AW-1:0] seq_addr(input logic [2:0] s);
    case (s)
      3'd0:    seq_addr = AW'(11'h4E3);
      3'd1:    seq_addr = AW'(11'h0B8);
      3'd2:    seq_addr = AW'(11'h744);
      3'd3:    seq_addr = AW'(11'h3C3);
      default: seq_addr = AW'(11'h0F8);
    endcase
  endfunction

  wire idle    = (st == S_IDLE);
  wire ram_rd  = idle & nv_n & ~ce_n & we_n;
  wire ram_wr  = idle & nv_n & ~ce_n & ~we_n;
  wire hw_st_c = ~nv_n & ~ce_n & ~we_n;
  wire hw_rc_c = ~nv_n & ~ce_n & we_n & ~oe_n;
  wire last    = ram_rd & (step == 3'd5);
  wire sw_st   = last & (addr == AW'(11'h13F));
  wire sw_rc   = last & (addr == AW'(11'h0C7));
  wire go_st   = idle & ((hw_st_c & ~hw_st_q) | sw_st);
  wire go_rc   = idle & ((hw_rc_c & ~hw_rc_q) | sw_rc);
  wire clr_now = (st == S_RCLR) && (cnt == '0);
  wire ld_now  = (st == S_RCLR) && (cnt == CLR_LAST);

  assign busy = ~idle;
  assign dout = dout_en ? rd_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RCLR;
      cnt     <= '0;
      step    <= '0;
      hw_st_q <= 1'b0;
      hw_rc_q <= 1'b0;
      done    <= 1'b0;
      dout_en <= 1'b0;
      rd_q    <= '0;
    end else begin
      hw_st_q <= hw_st_c;
      hw_rc_q <= hw_rc_c;
      done    <= 1'b0;
      dout_en <= ram_rd & ~oe_n;
      if (ram_rd) rd_q <= ram[addr];
      if (idle && !ce_n) begin
        if (ram_rd && step < 3'd5 && addr == seq_addr(step)) step <= step + 3'd1;
        else if (ram_rd && addr == seq_addr(3'd0))            step <= 3'd1;
        else                                                  step <= 3'd0;
      end
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (go_st)      st <= S_STORE;
          else if (go_rc) st <= S_RCLR;
        end
        S_STORE:
          if (cnt == ST_LAST) begin st <= S_IDLE; done <= 1'b1; end
          else cnt <= cnt + 1'b1;
        S_RCLR:
          if (cnt == CLR_LAST) begin st <= S_RLOAD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default:
          if (cnt == LD_LAST) begin st <= S_IDLE; done <= 1'b1; end
          else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (go_st)
      for (int i = 0; i < WORDS; i++) shadow[i] <= ram[i];
    if (ld_now)
      for (int i = 0; i < WORDS; i++) ram[i] <= shadow[i];
    else if (clr_now)
      for (int i = 0; i < WORDS; i++) ram[i] <= '0;
    else if (ram_wr)
      ram[addr] <= din;
  end

  // R9
  lockout_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_en);

  // R3
  nv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_n |=> !dout_en);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R11
  powerup_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> busy);
endmodule

// File: tb/sram_shadow_ctrl_test.sv
module sram_shadow_ctrl_test;
  localparam int STORE_CYC  = 64;
  localparam int RECALL_CYC = 8;

  logic        clk = 0, rst_n = 0;
  logic        ce_n = 1, oe_n = 1, we_n = 1, nv_n = 1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, busy, done;
  int          n_chk = 0, n_bad = 0;

  sram_shadow_ctrl #(.AW(11), .DW(8), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .done(done));

  always #5 clk = ~clk;

  // {write, addr[10:0], data[7:0]}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 11'h000, 8'h3C}, {1'b1, 11'h7FF, 8'hC3}, {1'b1, 11'h2A5, 8'h5A}, {1'b1, 11'h15A, 8'hA5},
    {1'b0, 11'h000, 8'h3C}, {1'b0, 11'h7FF, 8'hC3}, {1'b0, 11'h2A5, 8'h5A}, {1'b0, 11'h15A, 8'hA5}};

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_idle();
    ce_n = 1; we_n = 1; oe_n = 1; nv_n = 1;
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; nv_n = 1; addr = a; din = d;
    @(negedge clk); set_idle();
  endtask

  task automatic rd(input logic [10:0] a, input logic oe, output logic [7:0] d, output logic e);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = oe; nv_n = 1; addr = a;
    @(negedge clk); d = dout; e = dout_en; set_idle();
  endtask

  task automatic rd_chk(input logic [10:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d; logic e;
    rd(a, 1'b0, d, e);
    chk(e && d == exp, tag, {e, d}, {1'b1, exp});
  endtask

  task automatic hw_trig(input logic store, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; nv_n = 0; addr = a; din = d;
    we_n = store ? 1'b0 : 1'b1; oe_n = store ? 1'b1 : 1'b0;
    @(negedge clk); set_idle();
  endtask

  task automatic wait_op(input int exp, input string tag);
    int c = 0;
    while (busy && c < 1000) begin c++; @(negedge clk); end
    chk(c == exp, tag, c, exp);
    chk(done == 1'b1, "R12 done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", done, 0);
  endtask

  task automatic seq(input int upto, input logic [10:0] fin);
    logic [7:0] d; logic e;
    logic [10:0] s [5] = '{11'h4E3, 11'h0B8, 11'h744, 11'h3C3, 11'h0F8};
    for (int i = 0; i < upto; i++) rd(s[i], 1'b0, d, e);
    if (upto == 5) rd(fin, 1'b0, d, e);
  endtask

  task automatic seq_tail(input int from, input logic [10:0] fin);
    logic [7:0] d; logic e;
    logic [10:0] s [5] = '{11'h4E3, 11'h0B8, 11'h744, 11'h3C3, 11'h0F8};
    for (int i = from; i < 5; i++) rd(s[i], 1'b0, d, e);
    rd(fin, 1'b0, d, e);
  endtask

  task automatic power_up();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(busy && !dout_en && !done && dout == 0, "R11 reset state", {busy, dout_en, done}, 3'b100);
    rst_n = 1;
    wait_op(RECALL_CYC, "R11 power-up recall length");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d; logic e;
    power_up();

    foreach (VEC[i]) begin
      if (VEC[i][19]) wr(VEC[i][18:8], VEC[i][7:0]);
      else rd_chk(VEC[i][18:8], VEC[i][7:0], "R1 ram read");
    end

    rd(11'h000, 1'b1, d, e);
    chk(!e && d == 0, "R2 oe high gives no output", {e, d}, 0);
    @(negedge clk);
    chk(!dout_en && dout == 0, "R2 idle output", {dout_en, dout}, 0);

    wr(11'h100, 8'h11);
    hw_trig(1'b1, 11'h100, 8'h5A);
    chk(!dout_en, "R3 no output in transfer mode", dout_en, 0);
    wait_op(STORE_CYC, "R4 store length");
    rd_chk(11'h100, 8'h11, "R3 din ignored in transfer mode");

    hw_trig(1'b1, 11'h000, 8'h00);
    wr(11'h100, 8'hEE);
    rd(11'h100, 1'b0, d, e);
    chk(!e && busy, "R9 no output while busy", {busy, e}, 2'b10);
    while (busy) @(negedge clk);
    rd_chk(11'h100, 8'h11, "R9 write dropped while busy");

    @(negedge clk); ce_n = 0; we_n = 0; nv_n = 0;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(!busy, "R4 held trigger fires once", busy, 0);
    set_idle();

    wr(11'h100, 8'h77);
    wr(11'h2A5, 8'h00);
    hw_trig(1'b0, 11'h000, 8'h00);
    wait_op(RECALL_CYC, "R5 recall length");
    rd_chk(11'h100, 8'h11, "R10 recall restores word");
    rd_chk(11'h2A5, 8'h5A, "R10 recall restores zeroed word");

    wr(11'h100, 8'h99);
    seq(5, 11'h0C7);
    chk(busy, "R7 sw recall starts", busy, 1);
    wait_op(RECALL_CYC, "R7 sw recall length");
    rd_chk(11'h100, 8'h11, "R10 repeat recall shadow unchanged");

    wr(11'h100, 8'h22);
    seq(3, 11'h000);
    rd(11'h000, 1'b0, d, e);
    seq_tail(3, 11'h13F);
    @(negedge clk);
    chk(!busy, "R8 off-sequence read aborts", busy, 0);
    seq(2, 11'h000);
    wr(11'h300, 8'h01);
    seq_tail(2, 11'h13F);
    @(negedge clk);
    chk(!busy, "R8 write aborts", busy, 0);

    seq(5, 11'h13F);
    chk(busy, "R6 sw store starts", busy, 1);
    wait_op(STORE_CYC, "R6 sw store length");
    wr(11'h100, 8'h33);
    hw_trig(1'b0, 11'h000, 8'h00);
    wait_op(RECALL_CYC, "R5 recall after sw store");
    rd_chk(11'h100, 8'h22, "R6 sw store captured word");

    wr(11'h100, 8'h44);
    power_up();
    rd_chk(11'h100, 8'h22, "R11 power-up recall restores");
    rd_chk(11'h7FF, 8'hC3, "R11 top word restored");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule